// File: doc/BRIEF.md
# ADC Output Interface Logic

This block is the digital side of a 12-bit sampling converter. A pair of active-low strobes, a chip select and a read/convert line, are merged with a logical OR. A falling edge of the merged strobe starts a conversion, so a conversion starts whichever of the two lines falls last. A ready flag drops for the whole conversion. The block then latches the result and raises ready again. The analog conversion is not part of the block: a 12-bit sample input stands in for it. That input is captured at the start edge and appears as the result after a fixed latency in system clocks.

The result can be read in two ways. The first is an 8-bit parallel bus with an output enable, where a byte-select input chooses the upper eight bits or the lower four. The second is a serial line that sends the most significant bit first. In internal-clock mode the block makes its own data clock. The same start edge that begins a conversion also begins sending the result of the previous conversion. In external-clock mode the host supplies the data clock, and a tag input is shifted in behind the word so that several converters can be chained. A format input picks straight binary or two's complement coding.

Top module: `adc_oif`

## Requirements
- R1: When ready is high, a falling edge of (cs_n OR rdconv) starts a conversion: ready goes low one clock later and stays low for exactly LAT clocks (default 20). The edge is detected by comparing the strobe's value at two consecutive clock edges.
- R2: Falling strobe edges that arrive while ready is low are ignored: they neither restart nor lengthen the conversion.
- R3: The result is the value of sample_i at the clock edge that detects the start. The result is updated only in the cycle in which ready returns high. Later changes of sample_i have no effect on it.
- R4: par_oe_o is 1 exactly when cs_n is 0 and rdconv is 1. While par_oe_o is 0, par_d_o reads all zeros.
- R5: With byte_sel = 0, par_d_o[7:0] carries result bits 11..4, with bit 11 on par_d_o[7]. With byte_sel = 1, par_d_o[7:4] carries result bits 3..0 and par_d_o[3:0] is 0.
- R6: With twos_fmt = 1, every output word (parallel and serial) has result bit 11 inverted, which gives two's complement coding. With twos_fmt = 0, the word is passed as straight binary.
- R7: With ext_clk = 0, a start edge loads the previous result, formatted with the twos_fmt value at that edge. dclk_o then gives exactly 12 high pulses, each lasting DIV clocks, with DIV low clocks before each pulse. sdata_o is the next bit, MSB first, at every rising edge of dclk_o, and it changes only after a falling edge of dclk_o.
- R8: With ext_clk = 1, the new result, formatted with the twos_fmt value at that moment, is loaded into the serial register when ready rises. Each falling edge of dclk_i shifts the word left by one bit, and tag_i enters at the LSB. sdata_o is the register MSB, so after 12 falling edges the tag bits follow the word.
- R9: After reset, ready is high, dclk_o and sdata_o are 0, and the held result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select |
| rdconv | input | 1 | Read (high) / convert (low) strobe |
| byte_sel | input | 1 | 0: upper eight result bits, 1: lower four bits |
| twos_fmt | input | 1 | 1: two's complement coding, 0: straight binary |
| ext_clk | input | 1 | 1: data clock from dclk_i, 0: data clock generated on dclk_o |
| sample_i | input | 12 | Stand-in for the converted analog value |
| tag_i | input | 1 | Serial input shifted in behind the word in external mode |
| dclk_i | input | 1 | External data clock |
| rdy_o | output | 1 | High when idle, low during a conversion |
| par_oe_o | output | 1 | Parallel bus drive enable (0 means high impedance) |
| par_d_o | output | 8 | Parallel data bus |
| dclk_o | output | 1 | Internally generated data clock |
| sdata_o | output | 1 | Serial data output |

## Verification
Assertions check on every cycle that a detected start drops ready, that ready cannot rise while the counter is still running, and that the held result changes only in the cycle ready rises. They also check that the serial MSB stays steady while the internal data clock is high, and that the twelfth pulse ends the stream. Other behaviour is shown only by the bench scenarios: both orders of strobe edges, a strobe pulse during a conversion being ignored, a sample that changes after the start, the byte and format selections on the bus, and the internal stream carrying the previous conversion's word. The scenarios also show the externally clocked stream handing over to the tag bits after twelve shifts.

// File: rtl/adc_oif_pkg.sv
`timescale 1ns/1ps
package adc_oif_pkg;
  // serial transmitter phase
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_LOW  = 2'd1,
    TX_HIGH = 2'd2
  } tx_st_e;

  // conversion events handed from the controller to the serial side
  typedef struct packed {
    logic start;
    logic done;
  } conv_evt_t;
endpackage

// File: rtl/adc_oif_rst_sync.sv
`timescale 1ns/1ps
module adc_oif_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/adc_oif_ctrl.sv
`timescale 1ns/1ps
module adc_oif_ctrl
  import adc_oif_pkg::*;
#(
  parameter int W   = 12,
  parameter int LAT = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rdconv,
  input  logic         twos_fmt,
  input  logic [W-1:0] sample_i,
  output logic         rdy_o,
  output conv_evt_t    evt_o,
  output logic [W-1:0] res_fmt_o,
  output logic [W-1:0] new_fmt_o
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(LAT - 1);
  localparam logic [W-1:0]  MSB_MASK = {1'b1, {(W-1){1'b0}}};

  logic          strb_q, strb_now;
  logic          rdy_q, rdy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  hold_q, hold_d;
  logic [W-1:0]  res_q, res_d;
  logic          start, done;

  assign strb_now = cs_n | rdconv;
  assign start    = strb_q & ~strb_now & rdy_q;
  assign done     = ~rdy_q & (cnt_q == '0);

  always_comb begin
    rdy_d  = rdy_q;
    cnt_d  = cnt_q;
    hold_d = hold_q;
    res_d  = res_q;
    if (start) begin
      rdy_d  = 1'b0;
      cnt_d  = CNT_LOAD;
      hold_d = sample_i;
    end else if (!rdy_q) begin
      if (cnt_q == '0) begin
        rdy_d = 1'b1;
        res_d = hold_q;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b1;
      rdy_q  <= 1'b1;
      cnt_q  <= '0;
      hold_q <= '0;
      res_q  <= '0;
    end else begin
      strb_q <= strb_now;
      rdy_q  <= rdy_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      res_q  <= res_d;
    end
  end

  assign rdy_o      = rdy_q;
  assign evt_o      = '{start: start, done: done};
  assign res_fmt_o  = twos_fmt ? (res_q ^ MSB_MASK) : res_q;
  assign new_fmt_o  = twos_fmt ? (hold_q ^ MSB_MASK) : hold_q;

  // R1
  start_drops_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !rdy_q);

  // R2
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_q && cnt_q != '0) |=> !rdy_q);

  // R3
  res_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q != $past(res_q)) |-> (rdy_q && !$past(rdy_q)));
endmodule

// File: rtl/adc_oif_par.sv
`timescale 1ns/1ps
module adc_oif_par #(
  parameter int W   = 12,
  parameter int BUS = 8
) (
  input  logic           cs_n,
  input  logic           rdconv,
  input  logic           byte_sel,
  input  logic [W-1:0]   word_i,
  output logic           oe_o,
  output logic [BUS-1:0] d_o
);
  localparam int LW  = W - BUS;
  localparam int PAD = BUS - LW;

  logic [BUS-1:0] hi_lane, lo_lane;

  for (genvar i = 0; i < BUS; i++) begin : g_lane
    assign hi_lane[i] = word_i[LW + i];
    if (i >= PAD) begin : g_lo
      assign lo_lane[i] = word_i[i - PAD];
    end else begin : g_pad
      assign lo_lane[i] = 1'b0;
    end
  end

  assign oe_o = ~cs_n & rdconv;
  assign d_o  = oe_o ? (byte_sel ? lo_lane : hi_lane) : '0;
endmodule

// File: rtl/adc_oif_ser.sv
`timescale 1ns/1ps
module adc_oif_ser
  import adc_oif_pkg::*;
#(
  parameter int W   = 12,
  parameter int DIV = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_clk,
  input  logic         dclk_i,
  input  logic         tag_i,
  input  logic         load_int,
  input  logic         load_ext,
  input  logic [W-1:0] word_int,
  input  logic [W-1:0] word_ext,
  output logic         dclk_o,
  output logic         sdata_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int NW = $clog2(W);
  localparam logic [PW-1:0] PH_LOAD = PW'(DIV - 1);
  localparam logic [NW-1:0] N_LAST  = NW'(W - 1);

  tx_st_e        st_q, st_d;
  logic [PW-1:0] ph_q, ph_d;
  logic [NW-1:0] np_q, np_d;
  logic [W-1:0]  sh_q, sh_d;
  logic          xclk_q, x_fall;

  assign x_fall = xclk_q & ~dclk_i;

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    np_d = np_q;
    sh_d = sh_q;
    if (load_int) begin
      sh_d = word_int;
      st_d = TX_LOW;
      ph_d = PH_LOAD;
      np_d = '0;
    end else if (load_ext) begin
      sh_d = word_ext;
      st_d = TX_IDLE;
    end else begin
      case (st_q)
        TX_LOW: begin
          if (ph_q == '0) begin
            ph_d = PH_LOAD;
            st_d = TX_HIGH;
          end else begin
            ph_d = ph_q - 1'b1;
          end
        end
        TX_HIGH: begin
          if (ph_q == '0) begin
            ph_d = PH_LOAD;
            sh_d = {sh_q[W-2:0], 1'b0};
            if (np_q == N_LAST) begin
              st_d = TX_IDLE;
            end else begin
              np_d = np_q + 1'b1;
              st_d = TX_LOW;
            end
          end else begin
            ph_d = ph_q - 1'b1;
          end
        end
        default: begin
          if (ext_clk && x_fall) sh_d = {sh_q[W-2:0], tag_i};
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      ph_q   <= '0;
      np_q   <= '0;
      sh_q   <= '0;
      xclk_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      np_q   <= np_d;
      sh_q   <= sh_d;
      xclk_q <= dclk_i;
    end
  end

  assign dclk_o  = (st_q == TX_HIGH);
  assign sdata_o = sh_q[W-1];

  // R7
  hi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_HIGH) |-> $stable(sh_q[W-1]));

  // R7
  last_pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_HIGH && ph_q == '0 && np_q == N_LAST && !load_int && !load_ext)
      |=> (st_q == TX_IDLE));
endmodule

// File: rtl/adc_oif.sv
`timescale 1ns/1ps
module adc_oif
  import adc_oif_pkg::*;
#(
  parameter int W   = 12,
  parameter int BUS = 8,
  parameter int LAT = 20,
  parameter int DIV = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           rdconv,
  input  logic           byte_sel,
  input  logic           twos_fmt,
  input  logic           ext_clk,
  input  logic [W-1:0]   sample_i,
  input  logic           tag_i,
  input  logic           dclk_i,
  output logic           rdy_o,
  output logic           par_oe_o,
  output logic [BUS-1:0] par_d_o,
  output logic           dclk_o,
  output logic           sdata_o
);
  logic         rst_int_n;
  conv_evt_t    evt;
  logic [W-1:0] res_fmt, new_fmt;
  logic         load_int, load_ext;

  adc_oif_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  adc_oif_ctrl #(.W(W), .LAT(LAT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cs_n      (cs_n),
    .rdconv    (rdconv),
    .twos_fmt  (twos_fmt),
    .sample_i  (sample_i),
    .rdy_o     (rdy_o),
    .evt_o     (evt),
    .res_fmt_o (res_fmt),
    .new_fmt_o (new_fmt)
  );

  adc_oif_par #(.W(W), .BUS(BUS)) u_par (
    .cs_n     (cs_n),
    .rdconv   (rdconv),
    .byte_sel (byte_sel),
    .word_i   (res_fmt),
    .oe_o     (par_oe_o),
    .d_o      (par_d_o)
  );

  assign load_int = evt.start & ~ext_clk;
  assign load_ext = evt.done  &  ext_clk;

  adc_oif_ser #(.W(W), .DIV(DIV)) u_ser (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ext_clk  (ext_clk),
    .dclk_i   (dclk_i),
    .tag_i    (tag_i),
    .load_int (load_int),
    .load_ext (load_ext),
    .word_int (res_fmt),
    .word_ext (new_fmt),
    .dclk_o   (dclk_o),
    .sdata_o  (sdata_o)
  );

  // R4
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    cs_n |-> (!par_oe_o && par_d_o == '0));
endmodule

// File: tb/adc_oif_bench.sv
`timescale 1ns/1ps
module adc_oif_bench;
  localparam int LAT = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, rdconv, byte_sel, twos_fmt, ext_clk, tag_i, dclk_i;
  logic [11:0] sample;
  logic        rdy_o, par_oe_o, dclk_o, sdata_o;
  logic [7:0]  par_d_o;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  adc_oif u_adc_oif (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rdconv(rdconv),
    .byte_sel(byte_sel), .twos_fmt(twos_fmt), .ext_clk(ext_clk),
    .sample_i(sample), .tag_i(tag_i), .dclk_i(dclk_i),
    .rdy_o(rdy_o), .par_oe_o(par_oe_o), .par_d_o(par_d_o),
    .dclk_o(dclk_o), .sdata_o(sdata_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [11:0] fmt(input logic [11:0] v, input logic t);
    return t ? (v ^ 12'h800) : v;
  endfunction

  // behavioural reference model, advanced at every rising edge
  bit          m_ready = 1'b1;
  int          m_cnt   = 0;
  logic [11:0] m_hold  = '0;
  logic [11:0] m_res   = '0;
  bit          m_strb_q = 1'b1;
  logic [11:0] m_tx    = '0;
  int          m_load_seq = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ready = 1'b1; m_cnt = 0; m_hold = '0; m_res = '0; m_strb_q = 1'b1;
    end else begin
      bit strb;
      strb = cs_n | rdconv;
      if (m_strb_q && !strb && m_ready) begin
        m_ready = 1'b0;
        m_cnt   = LAT;
        m_hold  = sample;
        if (!ext_clk) begin
          m_tx = fmt(m_res, twos_fmt);
          m_load_seq++;
        end
      end else if (!m_ready) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_ready = 1'b1;
          m_res   = m_hold;
        end
      end
      m_strb_q = strb;
    end
  end

  // compare outputs with the model away from the active edge
  int m_bit = -1;
  int m_pulses = 0;
  int seen_seq = 0;
  bit prev_dclk = 1'b0;
  int run = 0;
  int last_run = 0;

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      logic        exp_oe;
      logic [7:0]  exp_d;
      logic [11:0] f;
      if (seen_seq != m_load_seq) begin
        seen_seq = m_load_seq;
        m_bit    = 11;
        m_pulses = 0;
      end
      chk(rdy_o == m_ready, "R1 ready vs model", rdy_o, m_ready);
      exp_oe = !cs_n && rdconv;
      chk(par_oe_o == exp_oe, "R4 bus enable", par_oe_o, exp_oe);
      f = fmt(m_res, twos_fmt);
      exp_d = !exp_oe ? 8'h00 : (byte_sel ? {f[3:0], 4'h0} : f[11:4]);
      chk(par_d_o == exp_d, "R5 bus data", par_d_o, exp_d);
      if (!prev_dclk && dclk_o) begin
        if (m_bit < 0) chk(1'b0, "R7 unexpected dclk pulse", 1, 0);
        else begin
          chk(sdata_o == m_tx[m_bit], "R7 serial bit at rising dclk", sdata_o, m_tx[m_bit]);
          m_bit--;
        end
        m_pulses++;
      end
      prev_dclk = dclk_o;
      if (!rdy_o) run++;
      else begin
        if (run != 0) last_run = run;
        run = 0;
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [11:0] xw;
    cs_n = 1; rdconv = 1; byte_sel = 0; twos_fmt = 0; ext_clk = 1;
    tag_i = 0; dclk_i = 0; sample = '0; rst_n = 0;
    step(4);
    rst_n = 1;
    step(3);
    @(negedge clk);
    chk(rdy_o == 1'b1, "R9 ready after reset", rdy_o, 1);
    chk(dclk_o == 1'b0, "R9 dclk after reset", dclk_o, 0);
    chk(sdata_o == 1'b0, "R9 sdata after reset", sdata_o, 0);
    chk(par_oe_o == 1'b0, "R9 bus idle after reset", par_oe_o, 0);

    // conversion A: chip select first, then read/convert falls
    sample = 12'hA5C; step(1);
    cs_n = 0; step(1);
    rdconv = 0; step(2);
    sample = 12'h000; step(26);
    chk(last_run == LAT, "R1 busy length", last_run, LAT);
    rdconv = 1; step(1);
    @(negedge clk);
    chk(par_d_o == 8'hA5, "R3 result is start sample, upper byte", par_d_o, 8'hA5);
    byte_sel = 1; step(1);
    @(negedge clk);
    chk(par_d_o == 8'hC0, "R5 lower nibble on top pins", par_d_o, 8'hC0);
    byte_sel = 0; twos_fmt = 1; step(1);
    @(negedge clk);
    chk(par_d_o == 8'h25, "R6 msb inverted in twos format", par_d_o, 8'h25);
    twos_fmt = 0; step(1);

    // conversion B: read/convert low first, chip select falls; internal clock
    cs_n = 1; step(1);
    rdconv = 0; ext_clk = 0; sample = 12'h123; step(1);
    cs_n = 0; step(5);
    sample = 12'h7FF;
    cs_n = 1; step(1);
    cs_n = 0; step(60);
    chk(last_run == LAT, "R2 strobe during busy ignored", last_run, LAT);
    chk(m_pulses == 12, "R7 pulse count", m_pulses, 12);
    chk(m_tx == 12'hA5C, "R7 stream carried previous word", m_tx, 12'hA5C);
    rdconv = 1; step(1);
    @(negedge clk);
    chk(par_d_o == 8'h12, "R3 sample change after start ignored", par_d_o, 8'h12);

    // conversion C: external clock, two's complement, tag chaining
    ext_clk = 1; twos_fmt = 1; sample = 12'h3F1; step(1);
    rdconv = 0; step(26);
    chk(last_run == LAT, "R1 busy length ext mode", last_run, LAT);
    xw = fmt(12'h3F1, 1'b1);
    for (int k = 0; k < 14; k++) begin
      logic e;
      e = (k < 12) ? xw[11-k] : (k == 12);
      dclk_i = 1; step(2);
      @(negedge clk);
      chk(sdata_o == e, "R8 external shift bit", sdata_o, e);
      tag_i = (k == 0);
      step(1);
      dclk_i = 0; step(2);
    end
    chk(dclk_o == 1'b0, "R8 no internal clock in external mode", dclk_o, 0);
    step(2);
    finish_run();
  end
endmodule